// File: doc/BRIEF.md
# Alarm Match Interrupt

This block raises an alarm when the running wall-clock time reaches a programmed point. It holds four alarm target registers: minute, hour (24-hour BCD), day of month and weekday. Each register has its own exclude bit, so any field can be left out of the comparison. The block compares the targets only when the time keeper signals a minute update. If every field still included agrees with the current time at that moment, an alarm flag is set. The flag stays set until the host clears it.

The interrupt line is active low. It is shared with the countdown timer. The line is driven low when the timer requests service, or when the alarm flag is set and the alarm interrupt enable is on. The host turns the enable off while it reprograms the alarm. The flag can still set during that time, but it does not reach the line. The time keeper and the countdown timer are outside this block.

The flag is held by a two-state machine. In state `ST_CLEAR` the flag reads 0. A minute update with a match moves the machine to `ST_FLAGGED`, where the flag reads 1. A host write of 0 to the flag moves it back to `ST_CLEAR`, unless a match arrives in the same cycle. A host write of 1 leaves the state unchanged.

Top module: `alarm_irq_top`

## Requirements
- R1: After reset, `alarm_flag` is 0 and `irq_n` is 1. All four alarm registers reset with their exclude bit set, so a minute update before any programming sets no flag.
- R2: A write to an alarm register uses `cfg_sel` to pick the field: 0 = minute, 1 = hour, 2 = day of month, 3 = weekday. In `cfg_data`, bit 7 is the exclude bit and bits 6:0 are the BCD target. When `minute_tick` is high and every included target equals its current-time input, `alarm_flag` reads 1 from the next cycle. If any included field differs, the flag stays 0.
- R3: A field whose exclude bit is 1 does not take part in the match, whatever the value of its current-time input.
- R4: If all four exclude bits are 1, a minute update never sets `alarm_flag`.
- R5: Without `minute_tick`, `alarm_flag` does not go from 0 to 1, even when the current time matches the targets.
- R6: The hour target is a 24-hour BCD value compared on all bits. For example, a target of 8'h23 matches a current hour of 8'h23 but not 8'h11 or 8'h03.
- R7: Once set, `alarm_flag` stays 1 until a cycle with `flag_wr` = 1 and `flag_wr_val` = 0, after which it reads 0. A write with `flag_wr_val` = 1 leaves the flag unchanged.
- R8: If a clearing write and a matching minute update happen in the same cycle, the set wins and `alarm_flag` is 1 in the next cycle.
- R9: `irq_n` is 0 in the same cycle whenever `timer_req` is 1, or `alarm_flag` and `alarm_ie` are both 1. Otherwise `irq_n` is 1.
- R10: When `alarm_ie` is 0, the alarm flag still sets on a match but does not pull `irq_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| minute_tick | input | 1 | One-cycle strobe from the time keeper on each minute update |
| cur_minute | input | 7 | Current minute, BCD |
| cur_hour | input | 7 | Current hour, 24-hour BCD |
| cur_day | input | 7 | Current day of month, BCD |
| cur_wday | input | 7 | Current weekday code |
| cfg_we | input | 1 | Alarm register write strobe |
| cfg_sel | input | 2 | Alarm register select (0 minute, 1 hour, 2 day, 3 weekday) |
| cfg_data | input | 8 | Write data: bit 7 exclude, bits 6:0 target |
| alarm_ie | input | 1 | Alarm interrupt enable |
| flag_wr | input | 1 | Host write strobe for the alarm flag |
| flag_wr_val | input | 1 | Value written to the alarm flag (0 clears, 1 no effect) |
| timer_req | input | 1 | Countdown timer interrupt request, active high |
| alarm_flag | output | 1 | Alarm flag |
| irq_n | output | 1 | Shared interrupt line, active low |

## Verification
The assertions check these properties on every cycle:
- the interrupt line follows the timer request, the alarm flag and the enable;
- the flag never rises without a minute update;
- a set flag holds until a clearing write;
- a clearing write with no minute update returns the flag to 0.

The bench's scenarios are needed for the rest:
- the field comparison itself, including exclusion of single fields and of all four;
- the full-width 24-hour hour compare;
- the reset contents of the alarm registers;
- the priority of a match over a clearing write in the same cycle.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;
    localparam int NUM_FIELDS = 4;
    localparam int SEL_W      = $clog2(NUM_FIELDS);

    typedef enum logic [SEL_W-1:0] {
        FLD_MINUTE = 2'd0,
        FLD_HOUR   = 2'd1,
        FLD_DAY    = 2'd2,
        FLD_WDAY   = 2'd3
    } field_sel_t;

    typedef enum logic {
        ST_CLEAR   = 1'b0,
        ST_FLAGGED = 1'b1
    } flag_state_t;
endpackage

// File: rtl/alarm_regbank.sv
module alarm_regbank #(
    parameter int N     = 4,
    parameter int W     = 7,
    parameter int SEL_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [SEL_W-1:0]    wr_sel,
    input  logic [W:0]          wr_data,
    output logic [N-1:0]        excl,
    output logic [N-1:0][W-1:0] target
);
    localparam logic [W:0] RST_VAL = {1'b1, {W{1'b0}}};

    for (genvar g = 0; g < N; g++) begin : g_reg
        logic [W:0] reg_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                reg_q <= RST_VAL;
            end else if (wr_en && (wr_sel == SEL_W'(g))) begin
                reg_q <= wr_data;
            end
        end
        assign excl[g]   = reg_q[W];
        assign target[g] = reg_q[W-1:0];
    end
endmodule

// File: rtl/alarm_match.sv
module alarm_match #(
    parameter int N = 4,
    parameter int W = 7
) (
    input  logic [N-1:0][W-1:0] cur,
    input  logic [N-1:0][W-1:0] target,
    input  logic [N-1:0]        excl,
    output logic                hit
);
    logic [N-1:0] field_ok;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign field_ok[g] = excl[g] || (cur[g] == target[g]);
    end

    // A hit needs every field to agree and at least one field included.
    assign hit = (&field_ok) && !(&excl);
endmodule

// File: rtl/alarm_flag_fsm.sv
module alarm_flag_fsm
    import alarm_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_req,
    output logic flag
);
    flag_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR: begin
                if (set_evt) state_d = ST_FLAGGED;
            end
            ST_FLAGGED: begin
                // A match in the same cycle takes priority over a clear.
                if (clr_req && !set_evt) state_d = ST_CLEAR;
            end
            default: state_d = ST_CLEAR;
        endcase
    end

    always_comb begin
        flag = (state_q == ST_FLAGGED);
    end
endmodule

// File: rtl/alarm_irq_top.sv
module alarm_irq_top
    import alarm_irq_pkg::*;
#(
    parameter int FIELD_W = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               minute_tick,
    input  logic [FIELD_W-1:0] cur_minute,
    input  logic [FIELD_W-1:0] cur_hour,
    input  logic [FIELD_W-1:0] cur_day,
    input  logic [FIELD_W-1:0] cur_wday,
    input  logic               cfg_we,
    input  logic [SEL_W-1:0]   cfg_sel,
    input  logic [FIELD_W:0]   cfg_data,
    input  logic               alarm_ie,
    input  logic               flag_wr,
    input  logic               flag_wr_val,
    input  logic               timer_req,
    output logic               alarm_flag,
    output logic               irq_n
);
    logic [NUM_FIELDS-1:0][FIELD_W-1:0] cur_vec;
    logic [NUM_FIELDS-1:0][FIELD_W-1:0] tgt_vec;
    logic [NUM_FIELDS-1:0]              excl_vec;
    logic                               hit;

    assign cur_vec[FLD_MINUTE] = cur_minute;
    assign cur_vec[FLD_HOUR]   = cur_hour;
    assign cur_vec[FLD_DAY]    = cur_day;
    assign cur_vec[FLD_WDAY]   = cur_wday;

    alarm_regbank #(.N(NUM_FIELDS), .W(FIELD_W), .SEL_W(SEL_W)) regbank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_sel  (cfg_sel),
        .wr_data (cfg_data),
        .excl    (excl_vec),
        .target  (tgt_vec)
    );

    alarm_match #(.N(NUM_FIELDS), .W(FIELD_W)) match_i (
        .cur    (cur_vec),
        .target (tgt_vec),
        .excl   (excl_vec),
        .hit    (hit)
    );

    alarm_flag_fsm flag_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (minute_tick && hit),
        .clr_req (flag_wr && !flag_wr_val),
        .flag    (alarm_flag)
    );

    assign irq_n = !((alarm_flag && alarm_ie) || timer_req);
endmodule

// File: rtl/alarm_irq_chk.sv
module alarm_irq_chk (
    input logic clk,
    input logic rst_n,
    input logic minute_tick,
    input logic flag_wr,
    input logic flag_wr_val,
    input logic alarm_ie,
    input logic timer_req,
    input logic alarm_flag,
    input logic irq_n
);
    AST_TIMER_PULLS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        timer_req |-> !irq_n); // R9

    AST_ALARM_PULLS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_flag && alarm_ie) |-> !irq_n); // R9

    AST_IE_MASKS_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
        (!alarm_ie && !timer_req) |-> irq_n); // R10

    AST_NO_RISE_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!alarm_flag && !minute_tick) |=> !alarm_flag); // R5

    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_flag && !(flag_wr && !flag_wr_val)) |=> alarm_flag); // R7

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wr && !flag_wr_val && !minute_tick) |=> !alarm_flag); // R7
endmodule

bind alarm_irq_top alarm_irq_chk chk_i (.*);

// File: tb/alarm_irq_top_tb_top.sv
`timescale 1ns/1ps
module alarm_irq_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       minute_tick = 1'b0;
    logic [6:0] cur_minute = '0, cur_hour = '0, cur_day = '0, cur_wday = '0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_sel = '0;
    logic [7:0] cfg_data = '0;
    logic       alarm_ie = 1'b0;
    logic       flag_wr = 1'b0;
    logic       flag_wr_val = 1'b0;
    logic       timer_req = 1'b0;
    logic       alarm_flag, irq_n;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    alarm_irq_top dut_i (.*);

    // Vector: {minute, hour, day, weekday, expected flag}
    localparam int NVEC = 6;
    localparam logic [28:0] VEC [NVEC] = '{
        {7'h30, 7'h23, 7'h01, 7'h05, 1'b1},
        {7'h31, 7'h23, 7'h01, 7'h05, 1'b0},
        {7'h30, 7'h11, 7'h01, 7'h05, 1'b0},
        {7'h30, 7'h23, 7'h29, 7'h05, 1'b1},
        {7'h30, 7'h23, 7'h01, 7'h06, 1'b0},
        {7'h30, 7'h03, 7'h01, 7'h05, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_alarm(input logic [1:0] sel, input logic [7:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_data = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_time(input logic [6:0] m, input logic [6:0] h,
                            input logic [6:0] d, input logic [6:0] w);
        cur_minute = m; cur_hour = h; cur_day = d; cur_wday = w;
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        minute_tick = 1'b1;
        @(negedge clk);
        minute_tick = 1'b0;
    endtask

    task automatic flag_write(input logic v);
        @(negedge clk);
        flag_wr = 1'b1; flag_wr_val = v;
        @(negedge clk);
        flag_wr = 1'b0;
    endtask

    function automatic logic exp_irq_n(input logic f, input logic ie, input logic t);
        return !((f && ie) || t);
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 flag after reset", alarm_flag, 1'b0);
        check("R1 irq_n after reset", irq_n, 1'b1);
        set_time(7'h00, 7'h00, 7'h00, 7'h00);
        pulse_tick();
        check("R1 reset registers all excluded", alarm_flag, 1'b0);

        // Program: minute 30, hour 23, day excluded, weekday 5
        write_alarm(2'd0, 8'h30);
        write_alarm(2'd1, 8'h23);
        write_alarm(2'd2, 8'h80 | 8'h15);
        write_alarm(2'd3, 8'h05);
        alarm_ie = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            set_time(VEC[i][28:22], VEC[i][21:15], VEC[i][14:8], VEC[i][7:1]);
            pulse_tick();
            check($sformatf("R2 R3 R6 vector %0d flag", i), alarm_flag, VEC[i][0]);
            check($sformatf("R9 vector %0d irq_n", i), irq_n,
                  exp_irq_n(VEC[i][0], 1'b1, 1'b0));
            flag_write(1'b0);
        end

        // R5: matching time held for many cycles without a tick
        set_time(7'h30, 7'h23, 7'h01, 7'h05);
        repeat (10) @(negedge clk);
        check("R5 no set without tick", alarm_flag, 1'b0);

        // R7: write 1 has no effect, write 0 clears
        pulse_tick();
        check("R7 set", alarm_flag, 1'b1);
        flag_write(1'b1);
        check("R7 write 1 keeps flag", alarm_flag, 1'b1);
        repeat (5) @(negedge clk);
        check("R7 flag holds", alarm_flag, 1'b1);

        // R10: enable off masks the line, flag still visible
        alarm_ie = 1'b0;
        #0.5;
        check("R10 irq_n masked", irq_n, 1'b1);
        alarm_ie = 1'b1;
        #0.5;
        check("R9 irq_n from alarm", irq_n, 1'b0);

        // R8: clear and matching tick in same cycle: set wins
        @(negedge clk);
        minute_tick = 1'b1; flag_wr = 1'b1; flag_wr_val = 1'b0;
        @(negedge clk);
        minute_tick = 1'b0; flag_wr = 1'b0;
        check("R8 set wins over clear", alarm_flag, 1'b1);
        flag_write(1'b0);
        check("R7 clear", alarm_flag, 1'b0);

        // R10: flag sets while enable off
        alarm_ie = 1'b0;
        pulse_tick();
        check("R10 flag sets with enable off", alarm_flag, 1'b1);
        check("R10 irq_n stays high", irq_n, 1'b1);
        flag_write(1'b0);

        // R9: timer request alone
        timer_req = 1'b1;
        #0.5;
        check("R9 timer pulls irq_n low", irq_n, 1'b0);
        timer_req = 1'b0;
        #0.5;
        check("R9 irq_n released", irq_n, 1'b1);

        // R3: exclude minute only, other minute value still matches
        write_alarm(2'd0, 8'h80 | 8'h30);
        set_time(7'h45, 7'h23, 7'h01, 7'h05);
        pulse_tick();
        check("R3 minute excluded", alarm_flag, 1'b1);
        flag_write(1'b0);

        // R4: all four excluded
        write_alarm(2'd1, 8'h80 | 8'h23);
        write_alarm(2'd3, 8'h80 | 8'h05);
        set_time(7'h30, 7'h23, 7'h15, 7'h05);
        pulse_tick();
        check("R4 all excluded never sets", alarm_flag, 1'b0);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule